// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block turns one slow control level into the start-up sequence of a clock-generation core. While the control level is high the core is parked: the clock output drivers are disabled and loss-of-lock reporting is held off. When the level is released after a long enough high time, the block resets the core's digital logic and starts the analog self-calibration. It then counts out the acquisition interval and finally marks the outputs as running.

The control level arrives asynchronously. It passes through a two-flop synchroniser, and all edges are taken from the synchronised copy. A release that follows a high time shorter than the minimum is treated as a glitch and ignored. If no reference clock is present at the moment of release, the block waits until one appears and only then starts calibration. Raising the control level at any point aborts the sequence and returns the block to the parked state.

Top module: `pwrcal_seq`

## Requirements
- R1: After reset `out_en`, `dig_rst`, `cal_start` and `acquiring` are 0 and `lol_hold` is 1. The block stays parked until a qualified release.
- R2: While the synchronised control level is high the block is parked and `out_en` is 0. Driving `pdn_cal` high makes `out_en` fall three clock edges later.
- R3: A release after fewer than `MIN_HIGH_CYC` cycles of synchronised high level is ignored, and the block stays parked. A release after `MIN_HIGH_CYC` or more cycles is accepted.
- R4: An accepted release with `ref_ok` high raises `dig_rst` three clock edges after `pdn_cal` falls. `dig_rst` then stays high for exactly `RST_CYC` cycles.
- R5: `cal_start` rises as `dig_rst` ends and stays high until `cal_done` is sampled high.
- R6: One edge after `cal_done` is sampled, `acquiring` is high for exactly `ACQ_CYC` cycles. `out_en` is high from that edge onwards, and `acquiring` is 0 once the interval ends.
- R7: `lol_hold` is 1 while parked, while waiting for a reference, during reset and during calibration. It is 0 during acquisition and while running.
- R8: An accepted release while `ref_ok` is low leaves `dig_rst` at 0 for as long as `ref_ok` stays low. `dig_rst` rises one edge after `ref_ok` goes high.
- R9: Raising `pdn_cal` during calibration drops `cal_start` and returns the block to the parked state.
- R10: At most one of `dig_rst`, `cal_start` and `acquiring` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_cal | input | 1 | Asynchronous control level: high parks the core, a qualified falling edge starts the sequence |
| ref_ok | input | 1 | Reference clock present, synchronous to `clk` |
| cal_done | input | 1 | Calibration finished, synchronous to `clk` |
| out_en | output | 1 | Clock output drivers enabled |
| dig_rst | output | 1 | Reset pulse for the core's digital logic |
| cal_start | output | 1 | Calibration request, held until `cal_done` |
| acquiring | output | 1 | Acquisition interval in progress |
| lol_hold | output | 1 | Suppresses loss-of-lock reporting |

## Verification
The checks assume that `ref_ok` and `cal_done` are synchronous to `clk`. They also assume that `cal_done` is only raised in answer to a pending `cal_start`. The bench drives every input on the falling clock edge. It raises `cal_done` for a single cycle, and only after it has observed `cal_start`. The bench changes `pdn_cal` only on falling edges as well, so the synchroniser delay is a fixed number of edges and release timing can be checked to the cycle.

// File: rtl/pwrcal_pkg.sv
// Shared types for the power-down / calibration sequencer.
package pwrcal_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAITREF = 3'd1,
        ST_RESET   = 3'd2,
        ST_CAL     = 3'd3,
        ST_ACQ     = 3'd4,
        ST_RUN     = 3'd5
    } seq_state_t;
endpackage

// File: rtl/pwrcal_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2. It resets to 0, the level of an undriven pin that is pulled low.
module pwrcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwrcal_hightime.sv
// Measures how long the synchronised control level stays high and flags a
// falling edge that follows a high time of at least MIN_HIGH cycles.
// Assumes the input is already synchronous to clk.
module pwrcal_hightime #(
    parameter int MIN_HIGH = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rel_ok
);
    localparam int W = $clog2(MIN_HIGH + 1);
    localparam logic [W-1:0] LIMIT = W'(MIN_HIGH);

    logic [W-1:0] cnt;
    logic         level_d;

    // saturating count of high cycles, cleared while the level is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            level_d <= 1'b0;
        end else begin
            level_d <= level;
            if (!level)           cnt <= '0;
            else if (cnt < LIMIT) cnt <= cnt + 1'b1;
        end
    end

    // a falling edge qualifies only after a long enough high time
    always_comb rel_ok = level_d && !level && (cnt >= LIMIT);
endmodule

// File: rtl/pwrcal_fsm.sv
// Phase sequencer: parked -> (wait for reference) -> reset -> calibrate ->
// acquire -> run. A high control level returns it to parked from any state.
// Assumes cal_done and ref_ok are synchronous to clk.
module pwrcal_fsm
    import pwrcal_pkg::*;
#(
    parameter int RST_CYC = 8,
    parameter int ACQ_CYC = 150000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_lvl,
    input  logic       rel_ok,
    input  logic       ref_ok,
    input  logic       cal_done,
    output seq_state_t state
);
    localparam int MAXC = (RST_CYC > ACQ_CYC) ? RST_CYC : ACQ_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] ACQ_LAST = TW'(ACQ_CYC - 1);

    seq_state_t    nxt;
    logic [TW-1:0] tmr;

    // next-state decision; power-down overrides every phase
    always_comb begin
        nxt = state;
        if (pdn_lvl) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF:     if (rel_ok) nxt = ref_ok ? ST_RESET : ST_WAITREF;
                ST_WAITREF: if (ref_ok) nxt = ST_RESET;
                ST_RESET:   if (tmr == RST_LAST) nxt = ST_CAL;
                ST_CAL:     if (cal_done) nxt = ST_ACQ;
                ST_ACQ:     if (tmr == ACQ_LAST) nxt = ST_RUN;
                ST_RUN:     nxt = ST_RUN;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    // state register and phase timer, restarted on each change of phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                tmr <= '0;
            else if (state == ST_RESET || state == ST_ACQ)
                tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/pwrcal_seq.sv
// Top of the power-down / calibration sequencer: synchronises the control
// level, qualifies its release and decodes the phase into control outputs.
// Assumes ref_ok and cal_done are synchronous to clk; pdn_cal may be asynchronous.
module pwrcal_seq
    import pwrcal_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_HIGH_CYC = 100,
    parameter int RST_CYC      = 8,
    parameter int ACQ_CYC      = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_cal,
    input  logic ref_ok,
    input  logic cal_done,
    output logic out_en,
    output logic dig_rst,
    output logic cal_start,
    output logic acquiring,
    output logic lol_hold
);
    logic       pdn_lvl;
    logic       rel_ok;
    seq_state_t state;

    pwrcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pdn_cal), .q_sync(pdn_lvl)
    );

    pwrcal_hightime #(.MIN_HIGH(MIN_HIGH_CYC)) u_high (
        .clk(clk), .rst_n(rst_n), .level(pdn_lvl), .rel_ok(rel_ok)
    );

    pwrcal_fsm #(.RST_CYC(RST_CYC), .ACQ_CYC(ACQ_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pdn_lvl(pdn_lvl), .rel_ok(rel_ok),
        .ref_ok(ref_ok), .cal_done(cal_done), .state(state)
    );

    // decode the current phase into the control outputs
    always_comb begin
        dig_rst   = (state == ST_RESET);
        cal_start = (state == ST_CAL);
        acquiring = (state == ST_ACQ);
        out_en    = (state == ST_ACQ) || (state == ST_RUN);
        lol_hold  = (state == ST_OFF) || (state == ST_WAITREF) ||
                    (state == ST_RESET) || (state == ST_CAL);
    end
endmodule

// File: rtl/pwrcal_seq_chk.sv
// Property checker for pwrcal_seq, attached by bind below.
module pwrcal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pdn_lvl,
    input logic cal_done,
    input logic out_en,
    input logic dig_rst,
    input logic cal_start,
    input logic acquiring,
    input logic lol_hold
);
    // R2
    parked_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_lvl |=> !out_en);

    // R5
    cal_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && !cal_done && !pdn_lvl) |=> cal_start);

    // R6
    acq_ends_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(acquiring) && !$past(pdn_lvl)) |-> out_en);

    // R7
    lol_held_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_rst || cal_start) |-> (lol_hold && !out_en));

    // R7
    lol_free_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acquiring |-> !lol_hold);

    // R10
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dig_rst, cal_start, acquiring}));
endmodule

bind pwrcal_seq pwrcal_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pdn_lvl(pdn_lvl), .cal_done(cal_done),
    .out_en(out_en), .dig_rst(dig_rst), .cal_start(cal_start),
    .acquiring(acquiring), .lol_hold(lol_hold)
);

// File: tb/pwrcal_seq_test.sv
module pwrcal_seq_test;
    localparam int MINH = 20;
    localparam int RSTC = 4;
    localparam int ACQC = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_cal = 1'b0;
    logic ref_ok = 1'b0;
    logic cal_done = 1'b0;
    logic out_en, dig_rst, cal_start, acquiring, lol_hold;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwrcal_seq #(.SYNC_STAGES(2), .MIN_HIGH_CYC(MINH), .RST_CYC(RSTC), .ACQ_CYC(ACQC)) uut (
        .clk(clk), .rst_n(rst_n), .pdn_cal(pdn_cal), .ref_ok(ref_ok), .cal_done(cal_done),
        .out_en(out_en), .dig_rst(dig_rst), .cal_start(cal_start),
        .acquiring(acquiring), .lol_hold(lol_hold)
    );

    // columns: high cycles, ref_ok, sequence expected to start
    localparam int VEC [6][3] = '{
        '{5, 1, 0}, '{MINH-1, 1, 0}, '{MINH, 1, 1},
        '{MINH+40, 1, 1}, '{1, 1, 0}, '{MINH-1, 1, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // hold pdn_cal high for n rising edges; call and return at a falling edge
    task automatic pulse_high(input int n);
        pdn_cal = 1'b1;
        repeat (n) @(negedge clk);
        pdn_cal = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_en", out_en, 0);
        chk("R1 dig_rst", dig_rst, 0);
        chk("R1 cal_start", cal_start, 0);
        chk("R1 acquiring", acquiring, 0);
        chk("R1 lol_hold", lol_hold, 1);
        repeat (10) @(negedge clk);
        chk("R1 stays parked", dig_rst, 0);

        // R3 table of high times
        for (int i = 0; i < 6; i++) begin
            ref_ok = VEC[i][1][0];
            pulse_high(VEC[i][0]);
            repeat (3) @(negedge clk);
            chk("R3 release qualification", dig_rst, VEC[i][2]);
            if (VEC[i][2] == 0) chk("R3 stays parked", lol_hold, 1);
            repeat (8) @(negedge clk);
        end

        // R4 full sequence
        ref_ok = 1'b1;
        pulse_high(MINH + 5);
        cnt = 0;
        while (!dig_rst && cnt < 10) begin @(negedge clk); cnt++; end
        chk("R4 reset start delay", cnt, 3);
        cnt = 0;
        while (dig_rst && cnt < 20) begin cnt++; @(negedge clk); end
        chk("R4 reset length", cnt, RSTC);
        // R5
        chk("R5 cal_start after reset", cal_start, 1);
        repeat (10) @(negedge clk);
        chk("R5 cal_start held", cal_start, 1);
        chk("R7 lol_hold during cal", lol_hold, 1);
        chk("R2 out_en during cal", out_en, 0);
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
        chk("R5 cal_start drops", cal_start, 0);
        chk("R7 lol released in acq", lol_hold, 0);
        chk("R6 out_en in acq", out_en, 1);
        cnt = 0;
        while (acquiring && cnt < 200) begin cnt++; @(negedge clk); end
        chk("R6 acquisition length", cnt, ACQC);
        chk("R6 running out_en", out_en, 1);
        chk("R7 lol released running", lol_hold, 0);

        // R2 power-down from running
        pdn_cal = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 out_en before sync delay", out_en, 1);
        @(negedge clk);
        chk("R2 out_en disabled", out_en, 0);
        chk("R7 lol held parked", lol_hold, 1);
        repeat (MINH + 5) @(negedge clk);
        pdn_cal = 1'b0;

        // R9 abort during calibration
        repeat (3 + RSTC + 3) @(negedge clk);
        chk("R9 in calibration", cal_start, 1);
        pdn_cal = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 cal_start aborted", cal_start, 0);
        chk("R9 parked lol_hold", lol_hold, 1);
        repeat (MINH + 5) @(negedge clk);

        // R8 pending on missing reference
        ref_ok = 1'b0;
        pdn_cal = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 no reset without ref", dig_rst, 0);
        chk("R8 lol_hold pending", lol_hold, 1);
        chk("R8 out_en pending", out_en, 0);
        ref_ok = 1'b1;
        @(negedge clk);
        chk("R8 reset on ref", dig_rst, 1);
        chk("R10 only reset phase", cal_start + acquiring, 0);

        finish_run();
    end
endmodule